// File: doc/BRIEF.md
# Display Host Register Bank

This block is the host-facing storage of an eight-character dot-matrix display controller. A processor reaches it over an 8-bit parallel data bus, with a 3-bit digit/row address, two mode lines, an active-low flash-select line and active-low chip enable, write, read and reset strobes. Each access is steered to one of five storage areas: a one-bit-per-digit flash map, a custom-glyph index register, a custom-glyph dot store, a control byte and the eight-entry character memory. Every area can be written and read back.

The stored state goes to the display scan and attribute logic: the character memory and flash map as flat vectors, the control byte, and a separate scan lookup port into the custom-glyph dot store. A character entry holds either a 7-bit glyph code (bit 7 clear) or a 4-bit custom-glyph index in bits 3..0 (bit 7 set). The bank does not interpret entries; it only stores them. Reset and the control-byte clear command are self-timed, run for a fixed number of clocks and raise a busy flag during which host writes are dropped.

Top module: `disp_regbank`

## Requirements
- R1: With flash_sel_n low, a write stores wdata bit 0 into flash bit [addr] whatever mode is; a read returns that bit in rdata bit 0 with bits 7..1 zero.
- R2: With flash_sel_n high and mode 2'b00, a write stores wdata[3:0] as the glyph index and ignores wdata[7:4]; a read returns the index in rdata[3:0] with bits 7..4 zero.
- R3: With flash_sel_n high and mode 2'b01, a write stores wdata[4:0] as the dots of row addr (0..6) of the glyph selected by the glyph index; a read returns them in rdata[4:0] with bits 7..5 zero; row 7 writes are dropped and row 7 reads give 0; scan_dots returns the dots for scan_glyph/scan_row.
- R4: With flash_sel_n high and mode 2'b11, a write stores all eight data bits into character entry [addr], visible on char_flat[8*addr+7:8*addr] and read back unchanged.
- R5: With flash_sel_n high and mode 2'b10, a write stores the control byte regardless of addr; bit 5 is read-only and always reads 0, so writing 8'h7F reads back 8'h5F.
- R6: A write commits at the first rising clock edge that sees wr_n high after an edge that saw it low, only if ce_n is low at that edge; no state changes while wr_n is held low, and a strobe with ce_n high changes nothing.
- R7: While rst_n is low, and for 3 clocks after it rises, busy is 1; reset sets the flash map and control byte to 0 and every character entry to 8'h20.
- R8: Writing the control byte with bit 7 set makes every character entry 8'h20 and the flash map 0 on the same edge, keeps the other written control bits, holds busy for 3 clocks, and bit 7 reads 0 from the edge where busy falls.
- R9: A write that commits while busy is 1 has no effect on any storage area.
- R10: rdata is 0 whenever ce_n or rd_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock; all state moves on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset, starts the init window |
| ce_n | input | 1 | Active-low chip enable |
| wr_n | input | 1 | Active-low write strobe, commits on its release |
| rd_n | input | 1 | Active-low read strobe |
| flash_sel_n | input | 1 | Low selects the flash map |
| mode | input | 2 | Area select when flash_sel_n is high |
| addr | input | 3 | Digit or glyph-row address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| busy | output | 1 | Reset or clear window in progress |
| char_flat | output | 64 | Character entries, entry i in bits 8i+7..8i |
| flash_bits | output | 8 | Flash map, bit i for digit i |
| ctrl_word | output | 8 | Control byte |
| scan_glyph | input | 4 | Scan lookup glyph index |
| scan_row | input | 3 | Scan lookup row |
| scan_dots | output | 5 | Dots of the looked-up row |

## Verification
On every cycle the assertions check that storage is frozen while busy, that a clear fills the character and flash areas at the moment it starts, that the clear bit never outlives the busy window, that the read-only control bit survives control writes, and that a held-low write strobe changes nothing. Only the bench scenarios show the address decode of each area, the zero-filled upper read bits, the dropped row 7, the exact busy length after reset and clear, and the effect of a strobe with chip enable high.

// File: rtl/disp_regbank_pkg.sv
package disp_regbank_pkg;

    localparam int DIGITS     = 8;
    localparam int AW         = $clog2(DIGITS);
    localparam int DW         = 8;
    localparam int GLYPHS     = 16;
    localparam int GW         = $clog2(GLYPHS);
    localparam int GROWS      = 7;
    localparam int GCOLS      = 5;
    localparam logic [DW-1:0] BLANK_CODE = 8'h20;
    localparam int CLR_BIT    = 7;
    localparam int RO_BIT     = 5;

    typedef enum logic [2:0] {
        AREA_FLASH,
        AREA_GIDX,
        AREA_GROW,
        AREA_CTRL,
        AREA_CHAR
    } area_e;

endpackage

// File: rtl/bank_bus_decode.sv
module bank_bus_decode
    import disp_regbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       wr_n,
    input  logic       flash_sel_n,
    input  logic [1:0] mode,
    output area_e      area,
    output logic       wr_release
);

    typedef struct packed {
        logic wr_n;
    } dec_st_t;

    dec_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wr_n = wr_n;
        if (!flash_sel_n) begin
            area = AREA_FLASH;
        end else begin
            case (mode)
                2'b00:   area = AREA_GIDX;
                2'b01:   area = AREA_GROW;
                2'b10:   area = AREA_CTRL;
                default: area = AREA_CHAR;
            endcase
        end
        wr_release = !st_q.wr_n && wr_n && !ce_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{wr_n: 1'b1};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bank_init_seq.sv
module bank_init_seq #(
    parameter int INIT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(INIT_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start)                st_d.cnt = LOAD;
        else if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
        busy = (st_q.cnt != '0) || !rst_n;
        done = (st_q.cnt == CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: LOAD};
        else        st_q <= st_d;
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy) else $error("start did not raise busy"); // R8

endmodule

// File: rtl/bank_glyph_store.sv
module bank_glyph_store
    import disp_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             we,
    input  logic [GW-1:0]    w_glyph,
    input  logic [AW-1:0]    w_row,
    input  logic [GCOLS-1:0] w_dots,
    input  logic [GW-1:0]    ra_glyph,
    input  logic [AW-1:0]    ra_row,
    output logic [GCOLS-1:0] ra_dots,
    input  logic [GW-1:0]    rb_glyph,
    input  logic [AW-1:0]    rb_row,
    output logic [GCOLS-1:0] rb_dots
);

    localparam int DEPTH = GLYPHS * (1 << AW);

    logic [GCOLS-1:0] mem [DEPTH];
    logic             row_ok_w;

    always_comb begin
        row_ok_w = (int'(w_row) < GROWS);
        ra_dots  = (int'(ra_row) < GROWS) ? mem[{ra_glyph, ra_row}] : '0;
        rb_dots  = (int'(rb_row) < GROWS) ? mem[{rb_glyph, rb_row}] : '0;
    end

    always_ff @(posedge clk) begin
        if (we && row_ok_w) mem[{w_glyph, w_row}] <= w_dots;
    end

endmodule

// File: rtl/disp_regbank.sv
module disp_regbank
    import disp_regbank_pkg::*;
#(
    parameter int INIT_CYCLES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                wr_n,
    input  logic                rd_n,
    input  logic                flash_sel_n,
    input  logic [1:0]          mode,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic                busy,
    output logic [DIGITS*DW-1:0] char_flat,
    output logic [DIGITS-1:0]   flash_bits,
    output logic [DW-1:0]       ctrl_word,
    input  logic [GW-1:0]       scan_glyph,
    input  logic [AW-1:0]       scan_row,
    output logic [GCOLS-1:0]    scan_dots
);

    typedef struct packed {
        logic [DIGITS-1:0][DW-1:0] chr;
        logic [DIGITS-1:0]         flash;
        logic [DW-1:0]             ctrl;
        logic [GW-1:0]             gidx;
    } bank_st_t;

    localparam bank_st_t RST_ST = '{
        chr:   {DIGITS{BLANK_CODE}},
        flash: '0,
        ctrl:  '0,
        gidx:  '0
    };

    bank_st_t         st_d, st_q;
    area_e            area;
    logic             wr_release;
    logic             commit;
    logic             clr_start;
    logic             seq_done;
    logic             grow_we;
    logic [GCOLS-1:0] bus_dots;

    bank_bus_decode u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .wr_n        (wr_n),
        .flash_sel_n (flash_sel_n),
        .mode        (mode),
        .area        (area),
        .wr_release  (wr_release)
    );

    bank_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (clr_start),
        .busy  (busy),
        .done  (seq_done)
    );

    bank_glyph_store u_glyph (
        .clk      (clk),
        .we       (grow_we),
        .w_glyph  (st_q.gidx),
        .w_row    (addr),
        .w_dots   (wdata[GCOLS-1:0]),
        .ra_glyph (st_q.gidx),
        .ra_row   (addr),
        .ra_dots  (bus_dots),
        .rb_glyph (scan_glyph),
        .rb_row   (scan_row),
        .rb_dots  (scan_dots)
    );

    always_comb begin
        st_d      = st_q;
        commit    = wr_release && !busy;
        clr_start = commit && (area == AREA_CTRL) && wdata[CLR_BIT];
        grow_we   = commit && (area == AREA_GROW);

        if (seq_done) st_d.ctrl[CLR_BIT] = 1'b0;

        if (commit) begin
            case (area)
                AREA_FLASH: st_d.flash[addr] = wdata[0];
                AREA_GIDX:  st_d.gidx        = wdata[GW-1:0];
                AREA_CHAR:  st_d.chr[addr]   = wdata;
                AREA_CTRL: begin
                    st_d.ctrl         = wdata;
                    st_d.ctrl[RO_BIT] = st_q.ctrl[RO_BIT];
                end
                default: ;
            endcase
        end

        if (clr_start) begin
            st_d.chr   = {DIGITS{BLANK_CODE}};
            st_d.flash = '0;
        end

        rdata = '0;
        if (!ce_n && !rd_n) begin
            case (area)
                AREA_FLASH: rdata = {{(DW-1){1'b0}}, st_q.flash[addr]};
                AREA_GIDX:  rdata = {{(DW-GW){1'b0}}, st_q.gidx};
                AREA_GROW:  rdata = {{(DW-GCOLS){1'b0}}, bus_dots};
                AREA_CTRL:  rdata = st_q.ctrl;
                default:    rdata = st_q.chr[addr];
            endcase
        end

        char_flat  = st_q.chr;
        flash_bits = st_q.flash;
        ctrl_word  = st_q.ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(st_q.chr) && $stable(st_q.flash) && $stable(st_q.gidx)))
        else $error("storage changed while busy"); // R9
    AST_CLEAR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ctrl[CLR_BIT]) |-> ((st_q.chr == {DIGITS{BLANK_CODE}}) && (st_q.flash == '0)))
        else $error("clear did not fill storage"); // R8
    AST_CLEAR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl[CLR_BIT] |-> busy)
        else $error("clear bit outside busy window"); // R8
    AST_RO_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_release && (area == AREA_CTRL)) |=> (ctrl_word[RO_BIT] == $past(ctrl_word[RO_BIT])))
        else $error("read-only control bit changed"); // R5
    AST_HELD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> $stable(st_q.chr))
        else $error("character entry changed during held strobe"); // R6

endmodule

// File: tb/tb_disp_regbank.sv
`timescale 1ns/1ps
module tb_disp_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        flash_sel_n = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic [2:0]  addr = 3'd0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        busy;
    logic [63:0] char_flat;
    logic [7:0]  flash_bits;
    logic [7:0]  ctrl_word;
    logic [3:0]  scan_glyph = 4'd0;
    logic [2:0]  scan_row = 3'd0;
    logic [4:0]  scan_dots;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    disp_regbank dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .rd_n(rd_n),
        .flash_sel_n(flash_sel_n), .mode(mode), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .char_flat(char_flat), .flash_bits(flash_bits),
        .ctrl_word(ctrl_word), .scan_glyph(scan_glyph), .scan_row(scan_row),
        .scan_dots(scan_dots)
    );

    // vector: {flash_sel_n, mode[1:0], addr[2:0], wdata[7:0], expected read[7:0]}
    localparam int NV = 9;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 2'b11, 3'd3, 8'hFF, 8'h01},  // R1 mode ignored
        {1'b0, 2'b00, 3'd5, 8'hFE, 8'h00},  // R1 only bit 0
        {1'b1, 2'b00, 3'd6, 8'hA5, 8'h05},  // R2 upper bits dropped
        {1'b1, 2'b01, 3'd2, 8'hFF, 8'h1F},  // R3 glyph 5 row 2
        {1'b1, 2'b01, 3'd7, 8'h1F, 8'h00},  // R3 row 7 dropped
        {1'b1, 2'b11, 3'd6, 8'h85, 8'h85},  // R4 custom index entry
        {1'b1, 2'b11, 3'd0, 8'h53, 8'h53},  // R4 glyph code entry
        {1'b1, 2'b10, 3'd4, 8'h7F, 8'h5F},  // R5 read-only bit
        {1'b1, 2'b10, 3'd1, 8'h1B, 8'h1B}   // R5 plain byte
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_bus(input logic f, input logic [1:0] m, input logic [2:0] a, input logic [7:0] d);
        flash_sel_n = f; mode = m; addr = a; wdata = d;
    endtask

    task automatic do_write(input logic f, input logic [1:0] m, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        set_bus(f, m, a, d);
        ce_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic do_read(input logic f, input logic [1:0] m, input logic [2:0] a, output logic [7:0] d);
        set_bus(f, m, a, 8'h00);
        ce_n = 1'b0; rd_n = 1'b0;
        #1;
        d = rdata;
        rd_n = 1'b1; ce_n = 1'b1;
    endtask

    initial begin
        #800000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rv;

        repeat (3) @(negedge clk);
        check(busy === 1'b1, "R7 busy in reset", busy, 1);
        check(char_flat === {8{8'h20}}, "R7 char reset", char_flat, {8{8'h20}});
        check(flash_bits === 8'h00 && ctrl_word === 8'h00, "R7 flash/ctrl reset",
              {flash_bits, ctrl_word}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy === 1'b1, "R7 busy 2 clocks after", busy, 1);
        @(negedge clk);
        check(busy === 1'b0, "R7 busy ends after 3", busy, 0);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][21], VEC[i][20:19], VEC[i][18:16], VEC[i][15:8]);
            do_read(VEC[i][21], VEC[i][20:19], VEC[i][18:16], rv);
            check(rv === VEC[i][7:0], $sformatf("R1-5 vector %0d (R1 R2 R3 R4 R5)", i), rv, VEC[i][7:0]);
        end

        scan_glyph = 4'd5; scan_row = 3'd2; #1;
        check(scan_dots === 5'h1F, "R3 scan port", scan_dots, 5'h1F);
        check(char_flat[55:48] === 8'h85, "R4 char_flat digit 6", char_flat[55:48], 8'h85);
        check(flash_bits === 8'h08, "R1 flash vector", flash_bits, 8'h08);

        do_read(1'b1, 2'b11, 3'd6, rv);
        rd_n = 1'b1; ce_n = 1'b0; #1;
        check(rdata === 8'h00, "R10 rd_n high", rdata, 0);
        ce_n = 1'b1; rd_n = 1'b0; #1;
        check(rdata === 8'h00, "R10 ce_n high", rdata, 0);
        rd_n = 1'b1;

        // strobe with ce_n high
        @(negedge clk);
        set_bus(1'b1, 2'b11, 3'd0, 8'h11);
        wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        check(char_flat[7:0] === 8'h53, "R6 ce_n high ignored", char_flat[7:0], 8'h53);

        // held strobe
        set_bus(1'b1, 2'b11, 3'd0, 8'h22);
        ce_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        check(char_flat[7:0] === 8'h53, "R6 held strobe", char_flat[7:0], 8'h53);
        wr_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
        check(char_flat[7:0] === 8'h22, "R6 commit on release", char_flat[7:0], 8'h22);

        // clear command then a write inside the busy window
        do_write(1'b1, 2'b10, 3'd0, 8'h9B);
        check(busy === 1'b1 && ctrl_word === 8'h9B, "R8 clear started", {busy, ctrl_word}, {1'b1, 8'h9B});
        check(char_flat === {8{8'h20}} && flash_bits === 8'h00, "R8 clear fill",
              char_flat, {8{8'h20}});
        set_bus(1'b1, 2'b11, 3'd1, 8'h77);
        ce_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
        check(busy === 1'b1 && ctrl_word[7] === 1'b1, "R8 still busy", {busy, ctrl_word}, {1'b1, 8'h9B});
        @(negedge clk);
        check(busy === 1'b0 && ctrl_word === 8'h1B, "R8 clear done", {busy, ctrl_word}, {1'b0, 8'h1B});
        check(char_flat[15:8] === 8'h20, "R9 busy write dropped", char_flat[15:8], 8'h20);

        // mid-run reset
        do_write(1'b0, 2'b00, 3'd2, 8'h01);
        do_write(1'b1, 2'b11, 3'd4, 8'h41);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(flash_bits === 8'h00 && ctrl_word === 8'h00 && char_flat === {8{8'h20}} && busy === 1'b1,
              "R7 mid-run reset", {flash_bits, ctrl_word}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R7 release", busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule